// File: doc/BRIEF.md
# Rational Polyphase Sample-Rate Converter

This block converts a stream of 16-bit signed samples from one rate to another by a fixed ratio UP/DOWN. With the default ratio of 160/147, a 44.1 kHz stream becomes a 48 kHz stream. In concept the input is padded with UP-1 zeros per sample and low-pass filtered at the raised rate, and then one value in every DOWN is kept. The block never forms the padded stream. A position register advances by DOWN after each output. Each time the position passes UP, one new input sample enters a short history line. For every kept output, the block multiply-accumulates over a single polyphase branch of the prototype filter, one tap per clock.

Input and output both use a valid/ready handshake. The input side asks for exactly the samples the next output needs. When DOWN exceeds UP, it asks for several samples between outputs. The coefficient table is computed at elaboration from the parameters.

Top module: `poly_resampler`

## Requirements
- R1: After reset the history holds zeros, the position is at output 0, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: Output m, with n = m·DOWN, i = floor(n/UP) and p = n mod UP, equals the sum over k = 0..TAPS−1 of h[p + k·UP]·x[i−k]. Here x is the accepted input sequence (x[j] = 0 for j < 0) and is treated as signed two's complement.
- R3: The prototype taps are h[j] = min(j+1, UP·TAPS−j) for j = 0..UP·TAPS−1. Table entry p·TAPS+k holds h[p+k·UP].
- R4: The full-precision sum is rounded to nearest as (sum + 2^(FRAC−1)) >> FRAC, an arithmetic shift, so ties round toward +∞.
- R5: A rounded value outside −32768..32767 is clamped to the nearer limit.
- R6: Output m is offered only after exactly floor(m·DOWN/UP)+1 inputs have been accepted. `in_ready_o` is high only while fewer than that many have been taken.
- R7: `in_ready_o` and `out_valid_o` are never high together. `out_valid_o` falls in the cycle after an output handshake.
- R8: Each output is preceded by exactly TAPS+1 cycles in which both `in_ready_o` and `out_valid_o` are low.
- R9: While `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` stays unchanged.
- R10: `in_data_i` is ignored in any cycle where `in_ready_o` is low, whatever `in_valid_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block accepts an input sample |
| in_data_i | input | 16 | Input sample, signed |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Sink accepts the output sample |
| out_data_o | output | 16 | Output sample, signed |

## Verification
Two instances are driven at once: one interpolating by 3/2 and one decimating by 2/5. The second shows whether several inputs are taken between outputs. A slow ramp with no stalls separates errors in branch selection and tap order, because each phase weights its neighbours differently. Small random values under random stalls on both sides separate backpressure and consumption-count faults from arithmetic ones, while garbage is driven whenever the input is not ready. Full-scale positive and negative runs, followed by full-range random data, tell clamping apart from wraparound. The odd sums produced by the ramp and the random data exercise the half-up rounding rule.

// File: rtl/poly_rsmp_pkg.sv
package poly_rsmp_pkg;

  typedef enum logic [1:0] {
    ST_FILL,
    ST_MAC,
    ST_FLUSH,
    ST_OUT
  } rsmp_state_e;

  // triangular prototype of length n
  function automatic int proto_tap(input int j, input int n);
    return ((j + 1) < (n - j)) ? (j + 1) : (n - j);
  endfunction

endpackage

// File: rtl/rsmp_coef_rom.sv
module rsmp_coef_rom
  import poly_rsmp_pkg::*;
#(
  parameter int UP     = 160,
  parameter int TAPS   = 4,
  parameter int COEF_W = 16,
  localparam int DEPTH = UP * TAPS,
  localparam int ADRW  = $clog2(DEPTH)
) (
  input  logic [ADRW-1:0]          addr_i,
  output logic signed [COEF_W-1:0] coef_o
);

  logic signed [COEF_W-1:0] rom_q [DEPTH];

  // branch-major layout: entry p*TAPS+k = h[p+k*UP]
  initial begin
    for (int p = 0; p < UP; p++) begin
      for (int k = 0; k < TAPS; k++) begin
        rom_q[p*TAPS+k] = COEF_W'(proto_tap(p + k*UP, DEPTH));
      end
    end
  end

  assign coef_o = rom_q[addr_i];

endmodule

// File: rtl/rsmp_history.sv
module rsmp_history #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int SELW   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SELW-1:0]   sel_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] hist_q [DEPTH];

  // hist_q[0] is the newest sample
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [DATA_W-1:0] src;
    if (g == 0) begin : g_head
      assign src = data_i;
    end else begin : g_body
      assign src = hist_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q[g] <= '0;
      else if (shift_i) hist_q[g] <= src;
    end
  end

  assign data_o = hist_q[sel_i];

endmodule

// File: rtl/rsmp_mac.sv
module rsmp_mac #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int TAPS      = 4,
  parameter int FRAC_BITS = 9,
  localparam int PW = DATA_W + COEF_W,
  localparam int AW = PW + $clog2(TAPS) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     en_i,
  input  logic                     fin_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [COEF_W-1:0] c_i,
  output logic [DATA_W-1:0]        res_o
);

  localparam logic signed [AW:0] HALF = (AW+1)'(1) <<< (FRAC_BITS - 1);
  localparam logic signed [AW:0] SMAX = (AW+1)'(2**(DATA_W-1) - 1);
  localparam logic signed [AW:0] SMIN = -SMAX - 1;

  logic signed [PW-1:0] prod_q;
  logic                 pv_q;
  logic signed [AW-1:0] acc_q, acc_sum;
  logic signed [AW:0]   rnd, shf;
  logic [DATA_W-1:0]    sat;

  assign acc_sum = acc_q + {{(AW-PW){prod_q[PW-1]}}, prod_q};
  assign rnd     = {acc_sum[AW-1], acc_sum} + HALF;
  assign shf     = rnd >>> FRAC_BITS;

  always_comb begin
    if (shf > SMAX)      sat = SMAX[DATA_W-1:0];
    else if (shf < SMIN) sat = SMIN[DATA_W-1:0];
    else                 sat = shf[DATA_W-1:0];
  end

  // product stage then accumulate; fin_i adds the last product
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      pv_q   <= 1'b0;
      acc_q  <= '0;
      res_o  <= '0;
    end else if (clear_i) begin
      pv_q  <= 1'b0;
      acc_q <= '0;
    end else begin
      prod_q <= x_i * c_i;
      pv_q   <= en_i;
      if (pv_q)  acc_q <= acc_sum;
      if (fin_i) res_o <= sat;
    end
  end

endmodule

// File: rtl/rsmp_ctrl.sv
module rsmp_ctrl
  import poly_rsmp_pkg::*;
#(
  parameter int UP   = 160,
  parameter int DOWN = 147,
  parameter int TAPS = 4,
  localparam int POSW = $clog2(UP + DOWN + 1),
  localparam int KW   = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int ADRW = $clog2(UP * TAPS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic            out_ready_i,
  output logic            out_valid_o,
  output logic            shift_o,
  output logic [KW-1:0]   tap_o,
  output logic [ADRW-1:0] addr_o,
  output logic            mac_en_o,
  output logic            fin_o,
  output logic            clear_o
);

  rsmp_state_e     state_q;
  logic [POSW-1:0] pos_q, pos_dec, pos_inc;
  logic [KW-1:0]   k_q;
  logic            need;

  // pos_q >= UP means an input is still owed
  assign need    = (state_q == ST_FILL) && (pos_q >= POSW'(UP));
  assign pos_dec = pos_q - POSW'(UP);
  assign pos_inc = pos_q + POSW'(DOWN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FILL;
      pos_q   <= POSW'(UP);
      k_q     <= '0;
    end else begin
      unique case (state_q)
        ST_FILL: if (in_valid_i && need) begin
          pos_q <= pos_dec;
          if (pos_dec < POSW'(UP)) state_q <= ST_MAC;
        end
        ST_MAC: begin
          if (k_q == KW'(TAPS - 1)) state_q <= ST_FLUSH;
          else                      k_q <= k_q + 1'b1;
        end
        ST_FLUSH: begin
          k_q     <= '0;
          state_q <= ST_OUT;
        end
        ST_OUT: if (out_ready_i) begin
          pos_q   <= pos_inc;
          state_q <= (pos_inc >= POSW'(UP)) ? ST_FILL : ST_MAC;
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  assign in_ready_o  = need;
  assign shift_o     = need && in_valid_i;
  assign out_valid_o = (state_q == ST_OUT);
  assign mac_en_o    = (state_q == ST_MAC);
  assign fin_o       = (state_q == ST_FLUSH);
  assign clear_o     = (state_q == ST_FILL) || (state_q == ST_OUT);
  assign tap_o       = k_q;
  assign addr_o      = ADRW'(pos_q) * ADRW'(TAPS) + ADRW'(k_q);

endmodule

// File: rtl/poly_resampler.sv
module poly_resampler #(
  parameter int UP        = 160,
  parameter int DOWN      = 147,
  parameter int TAPS      = 4,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int FRAC_BITS = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);

  localparam int KW   = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int ADRW = $clog2(UP * TAPS);

  logic                     shift, mac_en, fin, clear;
  logic [KW-1:0]            tap;
  logic [ADRW-1:0]          addr;
  logic [DATA_W-1:0]        hist_x;
  logic signed [COEF_W-1:0] coef;

  rsmp_ctrl #(.UP(UP), .DOWN(DOWN), .TAPS(TAPS)) u_ctrl (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .out_ready_i, .out_valid_o,
    .shift_o(shift), .tap_o(tap), .addr_o(addr),
    .mac_en_o(mac_en), .fin_o(fin), .clear_o(clear)
  );

  rsmp_history #(.DATA_W(DATA_W), .DEPTH(TAPS), .SELW(KW)) u_hist (
    .clk_i, .rst_ni, .shift_i(shift), .data_i(in_data_i),
    .sel_i(tap), .data_o(hist_x)
  );

  rsmp_coef_rom #(.UP(UP), .TAPS(TAPS), .COEF_W(COEF_W)) u_rom (
    .addr_i(addr), .coef_o(coef)
  );

  rsmp_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS),
             .FRAC_BITS(FRAC_BITS)) u_mac (
    .clk_i, .rst_ni, .clear_i(clear), .en_i(mac_en), .fin_i(fin),
    .x_i(hist_x), .c_i(coef), .res_o(out_data_o)
  );

endmodule

// File: rtl/poly_resampler_chk.sv
module poly_resampler_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o
);

  assert_rdy_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  assert_out_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |=> !out_valid_o);

  assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o);

  assert_data_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_data_o));

endmodule

bind poly_resampler poly_resampler_chk u_chk (.*);

// File: tb/sim_poly_resampler.sv
module sim_lane #(
  parameter int L = 3,
  parameter int M = 2,
  parameter int T = 4,
  parameter int F = 2,
  parameter int NIN = 200,
  parameter logic [15:0] SEED = 16'hace1
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   fails,
  output logic done
);

  localparam int NOUT = (NIN*L - 1) / M + 1;

  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] in_data, out_data;

  poly_resampler #(.UP(L), .DOWN(M), .TAPS(T), .FRAC_BITS(F)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  int          xs[$];
  int          n_sent, m_out, run;
  logic [15:0] lfsr, cur, prev_od;
  logic        prev_ov, prev_acc, first;

  function automatic int need(input int m);
    return (m*M)/L + 1;
  endfunction

  function automatic int tap(input int j);
    return ((j+1) < (L*T - j)) ? (j+1) : (L*T - j);
  endfunction

  function automatic logic [15:0] gen_val(input int i, input logic [15:0] r);
    if (i < 30)       return 16'(i*301 - 4000);
    else if (i < 110) return {{4{r[11]}}, r[11:0]};
    else if (i < 125) return 16'h7fff;
    else if (i < 140) return 16'h8000;
    else              return r;
  endfunction

  function automatic longint model(input int m, output bit clamp);
    longint acc;
    int n, i, p;
    acc = 0;
    n = m*M; i = n/L; p = n%L;
    for (int k = 0; k < T; k++) begin
      int j;
      j = i - k;
      if (j >= 0 && j < xs.size()) acc += longint'(tap(p + k*L)) * xs[j];
    end
    acc = (acc + (longint'(1) <<< (F-1))) >>> F;
    clamp = (acc > 32767) || (acc < -32768);
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return acc;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (L=%0d M=%0d, output %0d): got %0d expected %0d",
               tag, L, M, m_out, act, exp);
    end
  endtask

  initial begin
    longint exp_v;
    bit     clamp;
    logic   acc_now;
    in_valid = 0; out_ready = 0; in_data = '0;
    checks = 0; fails = 0; done = 0;
    n_sent = 0; m_out = 0; run = 0;
    lfsr = SEED; cur = gen_val(0, SEED);
    prev_ov = 0; prev_acc = 0; prev_od = '0; first = 1;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (first) begin
        chk("R1 in_ready after reset", longint'(in_ready), 1);
        chk("R1 out_valid after reset", longint'(out_valid), 0);
        first = 0;
      end
      if (!in_ready && !out_valid) run++;
      else begin
        if (out_valid && !prev_ov) chk("R8 busy cycles before output", run, T+1);
        run = 0;
      end
      if (in_ready) chk("R6 R7 in_ready only while inputs owed",
                        longint'(n_sent < need(m_out)), 1);
      if (out_valid) chk("R6 inputs taken before output", n_sent, need(m_out));
      if (prev_ov && !prev_acc) begin
        chk("R9 out_valid held", longint'(out_valid), 1);
        chk("R9 out_data held", longint'(out_data), longint'(prev_od));
      end
      out_ready = (m_out < 10) ? 1'b1 : (lfsr[5] | lfsr[7]);
      acc_now = out_valid && out_ready;
      if (acc_now) begin
        exp_v = model(m_out, clamp);
        if (clamp) chk("R5 clamped output", longint'($signed(out_data)), exp_v);
        else       chk("R2 R3 R4 R10 output value", longint'($signed(out_data)), exp_v);
      end
      if (n_sent < NIN) begin
        if (in_ready) begin
          in_valid = (n_sent < 30) ? 1'b1 : (lfsr[0] | lfsr[3]);
          in_data  = cur;
        end else begin
          // R10: garbage offered while not ready must be ignored
          in_valid = 1'b1;
          in_data  = lfsr ^ 16'h5a5a;
        end
      end else begin
        in_valid = 1'b0;
      end
      if (in_valid && in_ready) begin
        xs.push_back(int'($signed(cur)));
        n_sent++;
        cur = gen_val(n_sent, lfsr ^ 16'h3c96);
      end
      if (acc_now) m_out++;
      prev_ov = out_valid; prev_acc = acc_now; prev_od = out_data;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (m_out == NOUT) done = 1;
    end
  end

endmodule

module sim_poly_resampler;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   ca, fa, cb, fb;
  logic da, db;

  always #10 clk = ~clk;

  sim_lane #(.L(3), .M(2), .T(4), .F(2), .NIN(200), .SEED(16'hace1)) lane_up (
    .clk, .rst_n, .checks(ca), .fails(fa), .done(da)
  );

  sim_lane #(.L(2), .M(5), .T(3), .F(1), .NIN(200), .SEED(16'h1d2b)) lane_dn (
    .clk, .rst_n, .checks(cb), .fails(fb), .done(db)
  );

  initial begin
    int total, bad, cyc;
    cyc = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    while (!(da && db) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    repeat (2) @(posedge clk);
    total = ca + cb;
    bad   = fa + fb;
    if (!(da && db)) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

endmodule